// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block holds the 13-bit fetch address of a small 8-bit core with an 8K-word program memory, and the hardware stack that keeps return addresses. On each instruction cycle the decoder tells it which kind of flow-control event the current instruction is. The block then selects the next fetch address: the next sequential word, an absolute jump target, a subroutine call, a return, a computed write to the low address byte, or the interrupt vector. Calls and accepted interrupts push a return address onto a six-entry stack. The three return flavours pop it.

The clock runs at twice the instruction rate. A phase strobe marks the edge on which the address advances. Any change of flow costs one extra instruction cycle. During that bubble cycle the block only steps forward by one and ignores its requests. Stack overflow and underflow raise sticky flags. They are not trapped, and the stack keeps working as a ring.

All pins are plain control and status signals. There is no streamed data and no handshake.

Top module: `pcs_fetch_seq`

## Requirements
- R1: After reset the fetch address is 0, the stack level is 0, `stk_empty` is 1, and `stk_full`, `stk_ovf`, `stk_unf` and `flush` are all 0.
- R2: On a strobe edge (`phase_q1`=1) with no bubble, no interrupt, and `op_kind`=0 (sequential) or 7, the fetch address increments by one. 0x1FFF wraps to 0x0000.
- R3: On a clock edge with `phase_q1`=0, the fetch address and the stack do not change, whatever the request inputs are.
- R4: `op_kind`=2 (jump) loads `{page_bit, jmp_target[11:0]}` and leaves the stack unchanged.
- R5: `op_kind`=1 (call) loads the same target as a jump and pushes the call's own address plus one. The level rises by one.
- R6: `op_kind`=3, 4 and 5 (the three returns) load the top stack entry and pop it. The level falls by one.
- R7: `op_kind`=6 (low byte write) replaces address bits 7:0 with `low_data` and keeps bits 12:8.
- R8: A strobe edge with `irq_take`=1 loads address 1 and pushes the current address. A request on `op_kind` in the same cycle is ignored.
- R9: Every taken branch (kinds 1 to 6, or an interrupt) sets `flush` for the next instruction cycle. In that cycle `op_kind` and `irq_take` are ignored and the address increments by one.
- R10: A push when 6 entries are held sets the sticky `stk_ovf` flag. The level stays at 6 and the oldest entry is overwritten, so the following six pops return the six newest addresses.
- R11: A pop from an empty stack sets the sticky `stk_unf` flag, and the level stays at 0.
- R12: `stk_full` is 1 exactly when the level is 6, and `stk_empty` is 1 exactly when the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the instruction rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_q1 | input | 1 | Strobe marking the edge that advances the address |
| irq_take | input | 1 | Interrupt accepted at the end of the current instruction |
| op_kind | input | 3 | Flow kind: 0 seq, 1 call, 2 jump, 3 ret, 4 reti, 5 retlw, 6 low write, 7 seq |
| jmp_target | input | 12 | Target bits from the instruction word |
| page_bit | input | 1 | Page select bit from the status register |
| low_data | input | 8 | New value for the low address byte |
| fetch_addr | output | 13 | Current fetch address |
| stk_level | output | 3 | Number of valid stack entries |
| stk_full | output | 1 | Stack holds six entries |
| stk_empty | output | 1 | Stack holds no entries |
| stk_ovf | output | 1 | Sticky overflow flag |
| stk_unf | output | 1 | Sticky underflow flag |
| flush | output | 1 | Bubble cycle after a branch |

## Verification
The bench runs these stimulus patterns:
- Sequential runs up to the 0x1FFF boundary, which separate a correct 13-bit wrap from a carry into a wider register.
- Jumps and calls on both page values, which show whether the page bit reaches bit 12.
- A low-byte write from a high page, which shows that bits 12:8 are kept.
- A call followed by each return flavour, which shows that the pushed value is the call address plus one.
- An interrupt driven together with a jump request, which shows that the vector wins and that the interrupted address, not its successor, is saved.
- Call and interrupt requests placed in the bubble cycle and on non-strobe edges, which must all be ignored.
- Seven nested calls and then pops past empty, which expose the overwrite order of the ring and both sticky flags.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    OP_SEQ   = 3'd0,
    OP_CALL  = 3'd1,
    OP_JUMP  = 3'd2,
    OP_RET   = 3'd3,
    OP_RETI  = 3'd4,
    OP_RETLW = 3'd5,
    OP_LOWWR = 3'd6,
    OP_SEQ2  = 3'd7
  } flow_op_e;

  function automatic logic is_return(input flow_op_e op);
    return (op == OP_RET) || (op == OP_RETI) || (op == OP_RETLW);
  endfunction

endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     push_val,
  output logic [W-1:0]     top_val,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic             unf
);

  localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVMAX = LVL_W'(DEPTH);

  logic [W-1:0]     ring [DEPTH];
  logic [PTR_W-1:0] top_q;
  logic [PTR_W-1:0] top_up;
  logic [PTR_W-1:0] top_dn;

  assign top_up  = (top_q == LAST) ? '0 : top_q + PTR_W'(1);
  assign top_dn  = (top_q == '0) ? LAST : top_q - PTR_W'(1);
  assign top_val = ring[top_q];
  assign full    = (level == LVMAX);
  assign empty   = (level == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
      top_q <= LAST;
      level <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else if (push) begin
      ring[top_up] <= push_val;
      top_q        <= top_up;
      if (full) ovf   <= 1'b1;
      else      level <= level + LVL_W'(1);
    end else if (pop) begin
      top_q <= top_dn;
      if (empty) unf   <= 1'b1;
      else       level <= level - LVL_W'(1);
    end
  end

  // R10, R11: push and pop requests never coincide
  a_r10_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, pop}));

  // R10: level stays bounded by the depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVMAX);

  // R10: overflow flag is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R11: underflow flag is sticky, and a pop on empty keeps level zero
  a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (level == '0) && unf);

  // R12: full and empty are exclusive
  a_r12_full_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
  import pcs_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int JMP_W  = 12,
  parameter int LOW_W  = 8,
  parameter int IRQ_VEC = 1
) (
  input  logic [PC_W-1:0]  pc,
  input  logic             in_flush,
  input  logic             irq,
  input  flow_op_e         op,
  input  logic [JMP_W-1:0] target,
  input  logic             page,
  input  logic [LOW_W-1:0] low,
  input  logic [PC_W-1:0]  stack_top,
  output logic [PC_W-1:0]  pc_next,
  output logic             do_push,
  output logic             do_pop,
  output logic [PC_W-1:0]  push_val,
  output logic             branch
);

  localparam logic [PC_W-1:0] VEC = PC_W'(IRQ_VEC);

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] jump_addr;
  logic [PC_W-1:0] low_addr;

  assign pc_inc    = pc + PC_W'(1);
  assign jump_addr = {page, target};
  assign low_addr  = {pc[PC_W-1:LOW_W], low};

  always_comb begin
    pc_next  = pc_inc;
    do_push  = 1'b0;
    do_pop   = 1'b0;
    push_val = pc_inc;
    branch   = 1'b0;
    if (in_flush) begin
      pc_next = pc_inc;
    end else if (irq) begin
      pc_next  = VEC;
      do_push  = 1'b1;
      push_val = pc;
      branch   = 1'b1;
    end else begin
      unique case (op)
        OP_CALL: begin
          pc_next = jump_addr;
          do_push = 1'b1;
          branch  = 1'b1;
        end
        OP_JUMP: begin
          pc_next = jump_addr;
          branch  = 1'b1;
        end
        OP_RET, OP_RETI, OP_RETLW: begin
          pc_next = stack_top;
          do_pop  = 1'b1;
          branch  = 1'b1;
        end
        OP_LOWWR: begin
          pc_next = low_addr;
          branch  = 1'b1;
        end
        default: pc_next = pc_inc;
      endcase
    end
  end

  // R6: return kinds are the only pop sources
  a_r6_pop_source: assert final (!do_pop || (!in_flush && !irq && is_return(op)));

endmodule

// File: rtl/pcs_fetch_seq.sv
module pcs_fetch_seq
  import pcs_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int JMP_W   = 12,
  parameter int LOW_W   = 8,
  parameter int DEPTH   = 6,
  parameter int RST_VEC = 0,
  parameter int IRQ_VEC = 1,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_q1,
  input  logic             irq_take,
  input  logic [2:0]       op_kind,
  input  logic [JMP_W-1:0] jmp_target,
  input  logic             page_bit,
  input  logic [LOW_W-1:0] low_data,
  output logic [PC_W-1:0]  fetch_addr,
  output logic [LVL_W-1:0] stk_level,
  output logic             stk_full,
  output logic             stk_empty,
  output logic             stk_ovf,
  output logic             stk_unf,
  output logic             flush
);

  localparam logic [PC_W-1:0] RVEC = PC_W'(RST_VEC);

  logic [PC_W-1:0] pc_q;
  logic            flush_q;
  logic [PC_W-1:0] pc_next;
  logic            want_push;
  logic            want_pop;
  logic [PC_W-1:0] push_val;
  logic            branch;
  logic [PC_W-1:0] stack_top;
  flow_op_e        op;

  assign op         = flow_op_e'(op_kind);
  assign fetch_addr = pc_q;
  assign flush      = flush_q;

  pcs_next_pc #(
    .PC_W(PC_W), .JMP_W(JMP_W), .LOW_W(LOW_W), .IRQ_VEC(IRQ_VEC)
  ) u_next (
    .pc(pc_q), .in_flush(flush_q), .irq(irq_take), .op(op),
    .target(jmp_target), .page(page_bit), .low(low_data),
    .stack_top(stack_top), .pc_next(pc_next), .do_push(want_push),
    .do_pop(want_pop), .push_val(push_val), .branch(branch)
  );

  pcs_ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(phase_q1 && want_push), .pop(phase_q1 && want_pop),
    .push_val(push_val), .top_val(stack_top), .level(stk_level),
    .full(stk_full), .empty(stk_empty), .ovf(stk_ovf), .unf(stk_unf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RVEC;
      flush_q <= 1'b0;
    end else if (phase_q1) begin
      pc_q    <= pc_next;
      flush_q <= branch;
    end
  end

  // R2: plain sequential step
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q1 && !flush_q && !irq_take && (op_kind == 3'd0 || op_kind == 3'd7))
    |=> fetch_addr == ($past(fetch_addr) + PC_W'(1)));

  // R3: nothing moves off the strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q1 |=> $stable(fetch_addr) && $stable(stk_level) && $stable(flush));

  // R7: low-byte write keeps the upper bits
  a_r7_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q1 && !flush_q && !irq_take && op_kind == 3'd6)
    |=> fetch_addr[PC_W-1:LOW_W] == $past(fetch_addr[PC_W-1:LOW_W]));

  // R8: interrupt loads the vector
  a_r8_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q1 && !flush_q && irq_take) |=> fetch_addr == PC_W'(IRQ_VEC));

  // R9: bubble cycle only steps forward and ends the bubble
  a_r9_bubble_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q1 && flush_q)
    |=> (fetch_addr == ($past(fetch_addr) + PC_W'(1))) && !flush && $stable(stk_level));

endmodule

// File: tb/pcs_fetch_seq_bench.sv
module pcs_fetch_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_q1 = 1'b0;
  logic        irq_take = 1'b0;
  logic [2:0]  op_kind = 3'd0;
  logic [11:0] jmp_target = '0;
  logic        page_bit = 1'b0;
  logic [7:0]  low_data = '0;
  logic [12:0] fetch_addr;
  logic [2:0]  stk_level;
  logic        stk_full, stk_empty, stk_ovf, stk_unf, flush;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcs_fetch_seq u_pcs_fetch_seq (
    .clk(clk), .rst_n(rst_n), .phase_q1(phase_q1), .irq_take(irq_take),
    .op_kind(op_kind), .jmp_target(jmp_target), .page_bit(page_bit),
    .low_data(low_data), .fetch_addr(fetch_addr), .stk_level(stk_level),
    .stk_full(stk_full), .stk_empty(stk_empty), .stk_ovf(stk_ovf),
    .stk_unf(stk_unf), .flush(flush)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one instruction cycle: strobe edge then a quiet edge; returns just after strobe edge
  task automatic instr(input logic [2:0] op, input logic irq,
                       input logic [11:0] tgt, input logic pg, input logic [7:0] lo);
    @(negedge clk);
    phase_q1 = 1'b1; op_kind = op; irq_take = irq;
    jmp_target = tgt; page_bit = pg; low_data = lo;
    @(negedge clk);
    phase_q1 = 1'b0; op_kind = 3'd0; irq_take = 1'b0;
  endtask

  task automatic seq(); instr(3'd0, 1'b0, '0, 1'b0, '0); endtask

  task automatic t_reset();
    check("R1 addr", fetch_addr, 0);
    check("R1 level", stk_level, 0);
    check("R1 empty", stk_empty, 1);
    check("R1 full", stk_full, 0);
    check("R1 ovf", stk_ovf, 0);
    check("R1 unf", stk_unf, 0);
    check("R1 flush", flush, 0);
  endtask

  task automatic t_seq_hold();
    seq(); seq(); instr(3'd7, 1'b0, '0, 1'b0, '0);
    check("R2 seq", fetch_addr, 3);
    // requests on non-strobe edges
    @(negedge clk);
    op_kind = 3'd1; irq_take = 1'b1; jmp_target = 12'h555; page_bit = 1'b1;
    @(negedge clk); @(negedge clk);
    op_kind = 3'd0; irq_take = 1'b0;
    check("R3 hold addr", fetch_addr, 3);
    check("R3 hold level", stk_level, 0);
  endtask

  task automatic t_jump_bubble();
    instr(3'd2, 1'b0, 12'h123, 1'b1, '0);
    check("R4 jump", fetch_addr, 'h1123);
    check("R4 level", stk_level, 0);
    check("R9 flush set", flush, 1);
    instr(3'd1, 1'b1, 12'h456, 1'b0, '0);
    check("R9 bubble addr", fetch_addr, 'h1124);
    check("R9 bubble level", stk_level, 0);
    check("R9 flush clear", flush, 0);
  endtask

  task automatic t_call_ret();
    instr(3'd1, 1'b0, 12'h200, 1'b0, '0);
    check("R5 call", fetch_addr, 'h0200);
    check("R5 level", stk_level, 1);
    seq();
    instr(3'd3, 1'b0, 12'h0, 1'b0, '0);
    check("R6 ret", fetch_addr, 'h1125);
    check("R6 level", stk_level, 0);
    check("R9 ret flush", flush, 1);
    seq();
    check("R9 after ret", fetch_addr, 'h1126);
  endtask

  task automatic t_lowwr();
    instr(3'd6, 1'b0, 12'hFFF, 1'b0, 8'hA5);
    check("R7 low write", fetch_addr, 'h11A5);
    seq();
    check("R7 bubble", fetch_addr, 'h11A6);
  endtask

  task automatic t_irq();
    instr(3'd2, 1'b1, 12'h777, 1'b1, '0);
    check("R8 vector", fetch_addr, 1);
    check("R8 level", stk_level, 1);
    seq();
    check("R8 bubble", fetch_addr, 2);
    instr(3'd4, 1'b0, '0, 1'b0, '0);
    check("R6 reti", fetch_addr, 'h11A6);
    check("R6 reti level", stk_level, 0);
    seq();
    instr(3'd1, 1'b0, 12'h300, 1'b1, '0);
    check("R5 call page1", fetch_addr, 'h1300);
    seq();
    instr(3'd5, 1'b0, '0, 1'b0, '0);
    check("R6 retlw", fetch_addr, 'h11A8);
    seq();
  endtask

  task automatic t_wrap();
    instr(3'd2, 1'b0, 12'hFFE, 1'b1, '0);
    seq();
    check("R2 pre-wrap", fetch_addr, 'h1FFF);
    seq();
    check("R2 wrap", fetch_addr, 0);
  endtask

  task automatic t_overflow();
    int pushed[7];
    for (int k = 1; k <= 7; k++) begin
      pushed[k-1] = (k == 1) ? 1 : 16 * (k - 1) + 2;
      instr(3'd1, 1'b0, 12'(16 * k), 1'b0, '0);
      seq();
      if (k == 6) begin
        check("R12 full", stk_full, 1);
        check("R10 no ovf yet", stk_ovf, 0);
      end
    end
    check("R10 ovf", stk_ovf, 1);
    check("R10 level", stk_level, 6);
    for (int j = 6; j >= 1; j--) begin
      instr(3'd3, 1'b0, '0, 1'b0, '0);
      check("R10 pop order", fetch_addr, pushed[j]);
      seq();
    end
    check("R12 empty", stk_empty, 1);
    check("R11 no unf yet", stk_unf, 0);
  endtask

  task automatic t_underflow();
    instr(3'd3, 1'b0, '0, 1'b0, '0);
    check("R11 unf", stk_unf, 1);
    check("R11 level", stk_level, 0);
    seq();
    check("R10 ovf sticky", stk_ovf, 1);
    check("R11 unf sticky", stk_unf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq_hold();
    t_jump_bubble();
    t_call_ret();
    t_lowwr();
    t_irq();
    t_wrap();
    t_overflow();
    t_underflow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule